// File: doc/BRIEF.md
# Interlocked Handshake Word-Read Bus

This block joins a read-only requester and a memory responder over one set of shared lines. Address and data use the same lines in turn, and three control lines carry the handshake: a read request, an acknowledge and a data-ready. The requester side accepts a start command with a word address. It places the address on the shared lines and raises the request. It then gives the lines up and waits for the responder to return the stored word. A one-cycle completion pulse presents the word to the local logic.

Neither side assumes any fixed latency. Every step waits until the partner's last change has been observed, and each observed control line passes through a two-flop synchroniser first. The two sides could therefore run from unrelated clocks. Here they share one local clock. The acknowledge line is a wired-OR: the responder raises it to accept the address, and the requester raises it to accept the data. The responder holds a small word array, loaded at reset with a computed pattern.

Top module: `hsk_read_bus`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, done_o, all three control lines and both drive enables are low, and data_o is zero.
- R2: A read of address A returns, on data_o in the done_o cycle, the word ((A * 0x1357) XOR 0xC0DE) truncated to BUS_W bits. The same word is on bus_o from the cycle rdy_line_o first reads high.
- R3: Each read produces exactly this order of single-line changes on the control lines, one change per cycle at most: request high, acknowledge high, request low, acknowledge low, data-ready high, acknowledge high, data-ready low, acknowledge low.
- R4: While req_line_o is high, bus_o carries the address zero-extended to BUS_W bits. The responder starts driving only after the requester has stopped driving for at least two cycles.
- R5: mst_drv_o and slv_drv_o are never high in the same cycle.
- R6: done_o is high for exactly one cycle per read. In that cycle all three control lines are low.
- R7: start_i is ignored while busy_o is high. A start held or pulsed during a read starts no second read and does not alter the returned word.
- R8: Neither side reacts to a partner line change sooner than the synchroniser allows. The acknowledge rises no earlier than three cycles after the request rises.
- R9: A start presented in the done_o cycle is accepted, and busy_o is high in the following cycle. busy_o is low in the done_o cycle.
- R10: data_o keeps the last returned word until the next done_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one word read when idle |
| addr_i | input | ADDR_W | Word address sampled with start_i |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | BUS_W | Word returned by the last read |
| req_line_o | output | 1 | Read-request control line |
| ack_line_o | output | 1 | Wired-OR acknowledge line |
| rdy_line_o | output | 1 | Data-ready control line |
| bus_o | output | BUS_W | Resolved shared address/data lines |
| mst_drv_o | output | 1 | Requester drives the shared lines |
| slv_drv_o | output | 1 | Responder drives the shared lines |

## Verification
A state machine that is stuck or has skipped a step stops the control-line sequence. No done pulse follows, so a hang shows within a few tens of cycles. An out-of-order step appears as a wrong control-line change in the cycle where it happens. A mistimed bus hand-over shows as both drive enables high in the same cycle. A wrong captured address, or data latched before it settled, shows as a wrong word on bus_o when data-ready rises and again on data_o at the done pulse. A stray second read after a start during a busy period shows as an extra done pulse or a changed data_o.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    localparam int DEF_BUS_W       = 16;
    localparam int DEF_MEM_DEPTH   = 16;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        M_IDLE,
        M_ADDR,
        M_WAIT,
        M_TAKE,
        M_CLOSE
    } mst_state_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HOLD,
        S_DROP,
        S_SEND,
        S_CLOSE
    } slv_state_e;

    typedef struct packed {
        logic req;
        logic ack;
        logic drv;
    } mst_ctl_t;

    typedef struct packed {
        logic ack;
        logic rdy;
        logic drv;
    } slv_ctl_t;

    function automatic logic [31:0] word_seed(input int unsigned idx);
        return (idx * 32'h0000_1357) ^ 32'h0000_C0DE;
    endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q[s] <= '0;
                end else if (s == 0) begin
                    chain_q[s] <= async_i;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hsk_master.sv
module hsk_master
    import hsk_pkg::*;
#(
    parameter int BUS_W       = DEF_BUS_W,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ack_line_i,
    input  logic              rdy_line_i,
    input  logic [BUS_W-1:0]  bus_i,
    output logic              req_o,
    output logic              ack_o,
    output logic              drv_en_o,
    output logic [BUS_W-1:0]  drv_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [BUS_W-1:0]  data_o
);
    logic [1:0] seen;
    logic       ack_s;
    logic       rdy_s;

    hsk_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({rdy_line_i, ack_line_i}),
        .sync_o  (seen)
    );
    assign ack_s = seen[0];
    assign rdy_s = seen[1];

    mst_state_e        st_q,   st_d;
    mst_ctl_t          ctl_q,  ctl_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [BUS_W-1:0]  cap_q,  cap_d;
    logic [BUS_W-1:0]  res_q,  res_d;
    logic              done_q, done_d;

    always_comb begin
        st_d   = st_q;
        ctl_d  = ctl_q;
        addr_d = addr_q;
        cap_d  = cap_q;
        res_d  = res_q;
        done_d = 1'b0;
        unique case (st_q)
            M_IDLE: begin
                if (start_i) begin
                    addr_d = addr_i;
                    ctl_d  = '{req: 1'b1, ack: 1'b0, drv: 1'b1};
                    st_d   = M_ADDR;
                end
            end
            M_ADDR: begin
                if (ack_s) begin
                    ctl_d = '{req: 1'b0, ack: 1'b0, drv: 1'b0};
                    st_d  = M_WAIT;
                end
            end
            M_WAIT: begin
                if (rdy_s) begin
                    cap_d = bus_i;
                    ctl_d = '{req: 1'b0, ack: 1'b1, drv: 1'b0};
                    st_d  = M_TAKE;
                end
            end
            M_TAKE: begin
                if (!rdy_s) begin
                    ctl_d = '{req: 1'b0, ack: 1'b0, drv: 1'b0};
                    st_d  = M_CLOSE;
                end
            end
            M_CLOSE: begin
                if (!ack_s) begin
                    res_d  = cap_q;
                    done_d = 1'b1;
                    st_d   = M_IDLE;
                end
            end
            default: begin
                ctl_d = '0;
                st_d  = M_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= M_IDLE;
            ctl_q  <= '0;
            addr_q <= '0;
            cap_q  <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ctl_q  <= ctl_d;
            addr_q <= addr_d;
            cap_q  <= cap_d;
            res_q  <= res_d;
            done_q <= done_d;
        end
    end

    assign req_o      = ctl_q.req;
    assign ack_o      = ctl_q.ack;
    assign drv_en_o   = ctl_q.drv;
    assign drv_data_o = BUS_W'(addr_q);
    assign busy_o     = (st_q != M_IDLE);
    assign done_o     = done_q;
    assign data_o     = res_q;

    AST_REQ_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(req_o) |-> $past(ack_s)) else $error("request fell without acknowledge"); // R3
    AST_DONE_LINES_QUIET: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!ack_line_i && !rdy_line_i && !req_o)) else $error("done with active lines"); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R6
    AST_ADDR_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(addr_q)) else $error("address changed while busy"); // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(data_o)) else $error("result changed without done"); // R10
endmodule

// File: rtl/hsk_slave.sv
module hsk_slave
    import hsk_pkg::*;
#(
    parameter int BUS_W       = DEF_BUS_W,
    parameter int MEM_DEPTH   = DEF_MEM_DEPTH,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_line_i,
    input  logic             ack_line_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic             ack_o,
    output logic             rdy_o,
    output logic             drv_en_o,
    output logic [BUS_W-1:0] drv_data_o
);
    logic [1:0] seen;
    logic       req_s;
    logic       ack_s;

    hsk_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ack_line_i, req_line_i}),
        .sync_o  (seen)
    );
    assign req_s = seen[0];
    assign ack_s = seen[1];

    logic [BUS_W-1:0] mem_q [MEM_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_DEPTH; i++) begin
                mem_q[i] <= BUS_W'(word_seed(i));
            end
        end
    end

    slv_state_e        st_q,   st_d;
    slv_ctl_t          ctl_q,  ctl_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [BUS_W-1:0]  out_q,  out_d;

    always_comb begin
        st_d   = st_q;
        ctl_d  = ctl_q;
        addr_d = addr_q;
        out_d  = out_q;
        unique case (st_q)
            S_IDLE: begin
                if (req_s) begin
                    addr_d = bus_i[ADDR_W-1:0];
                    ctl_d  = '{ack: 1'b1, rdy: 1'b0, drv: 1'b0};
                    st_d   = S_HOLD;
                end
            end
            S_HOLD: begin
                if (!req_s) begin
                    ctl_d = '{ack: 1'b0, rdy: 1'b0, drv: 1'b0};
                    st_d  = S_DROP;
                end
            end
            S_DROP: begin
                if (!ack_s) begin
                    out_d = mem_q[addr_q];
                    ctl_d = '{ack: 1'b0, rdy: 1'b1, drv: 1'b1};
                    st_d  = S_SEND;
                end
            end
            S_SEND: begin
                if (ack_s) begin
                    ctl_d = '{ack: 1'b0, rdy: 1'b0, drv: 1'b0};
                    st_d  = S_CLOSE;
                end
            end
            S_CLOSE: begin
                if (!ack_s) begin
                    st_d = S_IDLE;
                end
            end
            default: begin
                ctl_d = '0;
                st_d  = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            ctl_q  <= '0;
            addr_q <= '0;
            out_q  <= '0;
        end else begin
            st_q   <= st_d;
            ctl_q  <= ctl_d;
            addr_q <= addr_d;
            out_q  <= out_d;
        end
    end

    assign ack_o      = ctl_q.ack;
    assign rdy_o      = ctl_q.rdy;
    assign drv_en_o   = ctl_q.drv;
    assign drv_data_o = out_q;

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> req_s) else $error("acknowledge without request"); // R3
    AST_RDY_NEEDS_REQ_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_o) |-> (!req_s && !req_line_i)) else $error("data-ready while request high"); // R3
    AST_RDY_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_o) |-> $past(ack_s)) else $error("data-ready fell without acknowledge"); // R3
endmodule

// File: rtl/hsk_read_bus.sv
module hsk_read_bus
    import hsk_pkg::*;
#(
    parameter int BUS_W       = DEF_BUS_W,
    parameter int MEM_DEPTH   = DEF_MEM_DEPTH,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int ADDR_W     = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [BUS_W-1:0]  data_o,
    output logic              req_line_o,
    output logic              ack_line_o,
    output logic              rdy_line_o,
    output logic [BUS_W-1:0]  bus_o,
    output logic              mst_drv_o,
    output logic              slv_drv_o
);
    logic             m_req, m_ack, m_en;
    logic [BUS_W-1:0] m_data;
    logic             s_ack, s_rdy, s_en;
    logic [BUS_W-1:0] s_data;
    logic             ack_line;
    logic [BUS_W-1:0] bus;

    assign ack_line = m_ack | s_ack;
    assign bus      = m_en ? m_data : (s_en ? s_data : '0);

    hsk_master #(
        .BUS_W       (BUS_W),
        .ADDR_W      (ADDR_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_master (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .ack_line_i (ack_line),
        .rdy_line_i (s_rdy),
        .bus_i      (bus),
        .req_o      (m_req),
        .ack_o      (m_ack),
        .drv_en_o   (m_en),
        .drv_data_o (m_data),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .data_o     (data_o)
    );

    hsk_slave #(
        .BUS_W       (BUS_W),
        .MEM_DEPTH   (MEM_DEPTH),
        .ADDR_W      (ADDR_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_slave (
        .clk        (clk),
        .rst        (rst),
        .req_line_i (m_req),
        .ack_line_i (ack_line),
        .bus_i      (bus),
        .ack_o      (s_ack),
        .rdy_o      (s_rdy),
        .drv_en_o   (s_en),
        .drv_data_o (s_data)
    );

    assign req_line_o = m_req;
    assign ack_line_o = ack_line;
    assign rdy_line_o = s_rdy;
    assign bus_o      = bus;
    assign mst_drv_o  = m_en;
    assign slv_drv_o  = s_en;

    AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (rst)
        !(m_en && s_en)) else $error("both sides drive the lines"); // R5
    AST_GAP_BEFORE_SLAVE_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(s_en) |-> (!$past(m_en) && !$past(m_en, 2))) else $error("no idle gap before hand-over"); // R4
    AST_ADDR_ON_LINES: assert property (@(posedge clk) disable iff (rst)
        (m_req && !s_en) |-> (bus[BUS_W-1:ADDR_W] == '0)) else $error("address not zero-extended"); // R4

    generate
        if (SYNC_STAGES >= 2) begin : g_sync_chk
            AST_ACK_AFTER_SYNC: assert property (@(posedge clk) disable iff (rst)
                $rose(s_ack) |-> ($past(m_req) && $past(m_req, 2))) else $error("acknowledge too early"); // R8
        end
    endgenerate
endmodule

// File: tb/hsk_read_bus_tb.sv
`timescale 1ns/1ps
module hsk_read_bus_tb;
    localparam int BUS_W   = 16;
    localparam int ADDR_W  = 4;
    localparam int TMO     = 300;
    localparam int WD_LIMIT = 20000;

    logic              clk = 1'b0;
    logic              rst;
    logic              start_i;
    logic [ADDR_W-1:0] addr_i;
    logic              busy_o, done_o;
    logic [BUS_W-1:0]  data_o;
    logic              req_line_o, ack_line_o, rdy_line_o;
    logic [BUS_W-1:0]  bus_o;
    logic              mst_drv_o, slv_drv_o;

    always #4 clk = ~clk;

    hsk_read_bus u_dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .data_o     (data_o),
        .req_line_o (req_line_o),
        .ack_line_o (ack_line_o),
        .rdy_line_o (rdy_line_o),
        .bus_o      (bus_o),
        .mst_drv_o  (mst_drv_o),
        .slv_drv_o  (slv_drv_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [BUS_W-1:0] exp_word(input int unsigned a);
        logic [31:0] t;
        t = (a * 32'h1357) ^ 32'hC0DE;
        return t[BUS_W-1:0];
    endfunction

    // expected event order: line 0=request 1=acknowledge 2=data-ready
    function automatic int ev_line(input int p);
        case (p)
            0: return 0; 1: return 1; 2: return 0; 3: return 1;
            4: return 2; 5: return 1; 6: return 2; default: return 1;
        endcase
    endfunction
    function automatic logic ev_val(input int p);
        return (p == 0 || p == 1 || p == 4 || p == 5);
    endfunction

    int   cyc = 0;
    int   ph = 0, last_ph = 0;
    int   seq_err = 0, coll = 0;
    int   t_req = 0, gap = 0, last_gap = 0;
    int   done_cnt = 0;
    logic [2:0] prev = 3'b000;

    always @(negedge clk) begin
        logic [2:0] cur, diff;
        int idx;
        cyc++;
        if (rst) begin
            prev = 3'b000;
            ph   = 0;
        end else begin
            cur  = {rdy_line_o, ack_line_o, req_line_o};
            diff = cur ^ prev;
            if (mst_drv_o && slv_drv_o) coll++;
            if (diff != 3'b000) begin
                if ($countones(diff) != 1) begin
                    seq_err++;
                end else begin
                    idx = diff[0] ? 0 : (diff[1] ? 1 : 2);
                    if (ph >= 8 || idx != ev_line(ph) || cur[idx] != ev_val(ph)) seq_err++;
                    if (ph == 0) t_req = cyc;
                    if (ph == 1) gap = cyc - t_req;
                    ph++;
                end
            end
            prev = cur;
            if (done_o) begin
                done_cnt++;
                last_ph  = ph;
                last_gap = gap;
                ph       = 0;
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > WD_LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < TMO; i++) begin
            @(negedge clk);
            if (done_o) begin ok = 1'b1; break; end
        end
    endtask

    task automatic wait_line(input int which, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < TMO; i++) begin
            @(negedge clk);
            if ((which == 0 && req_line_o) || (which == 2 && rdy_line_o)) begin
                ok = 1'b1; break;
            end
        end
    endtask

    task automatic post_done_checks(input string tag);
        int s0;
        s0 = seq_err;
        @(negedge clk);
        chk(done_o == 1'b0, "R6", {tag, " done width"}, done_o, 0);
        #1;
        chk(last_ph == 8, "R3", {tag, " event count"}, last_ph, 8);
        chk(seq_err == 0, "R3", {tag, " event order"}, seq_err, 0);
        chk(last_gap >= 3, "R8", {tag, " request-to-acknowledge gap"}, last_gap, 3);
    endtask

    task automatic t_reset();
        rst = 1'b1; start_i = 1'b0; addr_i = '0;
        repeat (4) @(negedge clk);
        chk(!busy_o && !done_o && !req_line_o && !ack_line_o && !rdy_line_o,
            "R1", "control idle in reset", {busy_o, done_o, req_line_o, ack_line_o, rdy_line_o}, 0);
        chk(!mst_drv_o && !slv_drv_o, "R1", "drivers off in reset", {mst_drv_o, slv_drv_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(data_o == '0 && !busy_o && !mst_drv_o, "R1", "state after reset", data_o, 0);
    endtask

    task automatic t_read(input logic [ADDR_W-1:0] a);
        bit ok;
        string tag;
        tag = $sformatf("read %0d", a);
        @(negedge clk);
        start_i = 1'b1; addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9", {tag, " busy after start"}, busy_o, 1);
        wait_line(0, ok);
        chk(ok && bus_o == BUS_W'(a), "R4", {tag, " address on lines"}, bus_o, BUS_W'(a));
        wait_line(2, ok);
        chk(ok && bus_o == exp_word(a), "R2", {tag, " word on lines"}, bus_o, exp_word(a));
        wait_done(ok);
        chk(ok && data_o == exp_word(a), "R2", {tag, " returned word"}, data_o, exp_word(a));
        chk(!req_line_o && !ack_line_o && !rdy_line_o, "R6", {tag, " lines low at done"},
            {req_line_o, ack_line_o, rdy_line_o}, 0);
        chk(busy_o == 1'b0, "R9", {tag, " not busy at done"}, busy_o, 0);
        post_done_checks(tag);
    endtask

    task automatic t_ignore_start();
        bit ok;
        int d0;
        d0 = done_cnt;
        @(negedge clk);
        start_i = 1'b1; addr_i = 4'd3;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        start_i = 1'b1; addr_i = 4'd12;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        wait_done(ok);
        chk(ok && data_o == exp_word(3), "R7", "busy start ignored, word", data_o, exp_word(3));
        post_done_checks("ignore");
        repeat (12) @(negedge clk);
        chk(busy_o == 1'b0, "R7", "no second read started", busy_o, 0);
        chk(done_cnt - d0 == 1, "R7", "single done pulse", done_cnt - d0, 1);
        chk(data_o == exp_word(3), "R10", "result held after done", data_o, exp_word(3));
    endtask

    task automatic t_back_to_back();
        bit ok;
        @(negedge clk);
        start_i = 1'b1; addr_i = 4'd9;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(ok);
        chk(ok && data_o == exp_word(9), "R2", "first of pair", data_o, exp_word(9));
        start_i = 1'b1; addr_i = 4'd6;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9", "start in done cycle accepted", busy_o, 1);
        chk(data_o == exp_word(9), "R10", "result held into next read", data_o, exp_word(9));
        wait_done(ok);
        chk(ok && data_o == exp_word(6), "R9", "second of pair", data_o, exp_word(6));
        post_done_checks("pair");
    endtask

    initial begin
        t_reset();
        t_read(4'd0);
        t_read(4'd15);
        t_read(4'd5);
        t_read(4'd10);
        t_ignore_start();
        t_back_to_back();
        repeat (4) @(negedge clk);
        chk(coll == 0, "R5", "no cycle with both drivers", coll, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule